// File: doc/BRIEF.md
# Two-Way Coherent Cache Tag Controller

This block keeps the tag and coherence bookkeeping for a small on-chip cache that is two-way set associative with 32-byte lines. A parameter sets the capacity to 8 KB (128 sets) or 16 KB (256 sets). Each line holds a tag and a two-bit coherence state. Each set holds one replacement bit. The line data, bus arbitration and memory sit outside the block.

Three request sources share one lookup path. The processor side presents a 32-bit physical address with a write flag and gets back, in the same cycle, hit, way and the line's current state. On a miss the same outputs name the victim way and show whether that victim needs a writeback. The fill side installs a tag into a way chosen by the caller. The snoop side applies external reads and invalidates. Only one request is serviced per cycle. A snoop wins over a fill, and a fill wins over a processor request.

Top module: `cache_tag_ctrl`

## Requirements
- R1: While reset is asserted, and from the moment it is released, every line is invalid and every replacement bit is 0. During reset all response outputs are 0. Reset is applied asynchronously and released on the second clock edge after `rst_n` rises.
- R2: Bits [4:0] of an address are ignored. Bits [11:5] select the set when capacity is 8 KB, or bits [12:5] when it is 16 KB. The bits above the set field form the tag. A processor request hits when a way holds a matching tag in any state other than invalid. `cpu_hit`, `cpu_way` and `cpu_state` then report that way and its state before any update. The state encoding is invalid=00, shared=01, exclusive=10, modified=11.
- R3: A fill writes the tag into `fill_way` at the clock edge. The line becomes exclusive (10) when `fill_shared` is 0 and shared (01) when it is 1.
- R4: A processor hit, or a fill, sets the set's replacement bit to the way that was not used. When both ways are valid, a miss names the way given by the replacement bit.
- R5: On a processor miss, `cpu_hit` is 0 and `cpu_state` is 00. `cpu_way` names the victim: way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise as in R4.
- R6: `cpu_wb` is 1 in the cycle of a processor miss whose victim line is modified, and 0 otherwise.
- R7: A processor write hit changes the line's state as follows. Exclusive becomes modified with no pulse. Shared becomes modified and `cpu_upgrade` is 1 for that cycle. Modified stays modified. A read hit leaves the state unchanged.
- R8: A snooped read that hits a line sets `snp_hit`. A modified line becomes shared and raises `snp_wb` for that cycle. An exclusive line becomes shared. A shared line stays shared.
- R9: A snooped invalidate (`snp_inv`=1) that hits makes the line invalid from any state and never raises `snp_wb`.
- R10: When requests arrive together, a snoop wins over a fill, and a fill wins over a processor request. A request that loses has no effect on any line or replacement bit. While it loses, the processor outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor lookup request |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | 32 | Processor physical address |
| cpu_hit | output | 1 | Processor request hit |
| cpu_way | output | 1 | Hit way, or victim way on a miss |
| cpu_state | output | 2 | State of the hit line (00 on miss) |
| cpu_upgrade | output | 1 | Upgrade/invalidate broadcast pulse on write hit to shared |
| cpu_wb | output | 1 | Writeback request for a modified victim |
| fill_req | input | 1 | Install a line |
| fill_addr | input | 32 | Address of the line being installed |
| fill_way | input | 1 | Way to install into |
| fill_shared | input | 1 | Another cache holds the line |
| snp_req | input | 1 | Snoop request |
| snp_inv | input | 1 | Snoop is an invalidate (0 = read) |
| snp_addr | input | 32 | Snooped physical address |
| snp_hit | output | 1 | Snoop found the line |
| snp_wb | output | 1 | Snoop read hit a modified line, writeback needed |

## Verification
The hardest case to reach is a processor miss in a full set whose replacement bit points at a modified line. The stimulus has to fill both ways, dirty one of them with a write, and steer the replacement bit with a hit to the other way before the conflicting miss arrives. A directed prologue builds this in both directions. It also covers the write upgrade from shared and the snoop-versus-processor collisions. A long random phase follows that keeps addresses inside two sets and four tags, so that evictions, upgrades and snoops on dirty lines keep recurring. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/ctc_pkg.sv
`timescale 1ns/1ps
package ctc_pkg;
  typedef enum logic [1:0] {
    CS_I = 2'b00,
    CS_S = 2'b01,
    CS_E = 2'b10,
    CS_M = 2'b11
  } coh_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD,
    OP_WR,
    OP_FILL,
    OP_SRD,
    OP_SINV
  } op_t;

  typedef struct packed {
    logic en;
    coh_t st;
    logic wb;
    logic upg;
  } coh_upd_t;
endpackage

// File: rtl/ctc_way_store.sv
`timescale 1ns/1ps
module ctc_way_store
  import ctc_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output coh_t             rd_state,
  input  logic             wr_st_en,
  input  logic             wr_tag_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  coh_t             wr_state
);
  logic [TAG_W-1:0] tag_q [SETS];
  coh_t             st_q  [SETS];

  // tags need no reset: a line is only visible through its state
  always_ff @(posedge clk) begin
    if (wr_tag_en) tag_q[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= CS_I;
    end else if (wr_st_en) begin
      st_q[wr_idx] <= wr_state;
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_state = st_q[rd_idx];

  // R3/R7/R8/R9: a granted state update is visible on the following cycle
  a_r3_state_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st_en |=> st_q[$past(wr_idx)] == $past(wr_state));
endmodule

// File: rtl/ctc_lru.sv
`timescale 1ns/1ps
module ctc_lru #(
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_lru,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_val
);
  logic [SETS-1:0] lru_q;
  logic [SETS-1:0] lru_d;

  always_comb begin
    lru_d = lru_q;
    if (upd_en) lru_d[upd_idx] = upd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  assign rd_lru = lru_q[rd_idx];

  // R4: the replacement bit follows each hit or fill
  a_r4_replace_bit_written: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> lru_q[$past(upd_idx)] == $past(upd_val));
endmodule

// File: rtl/ctc_victim.sv
`timescale 1ns/1ps
module ctc_victim
  import ctc_pkg::*;
(
  input  coh_t st_w0,
  input  coh_t st_w1,
  input  logic lru,
  output logic vic_way,
  output logic vic_dirty
);
  coh_t vic_st;

  always_comb begin
    if (st_w0 == CS_I)      vic_way = 1'b0;
    else if (st_w1 == CS_I) vic_way = 1'b1;
    else                    vic_way = lru;
    vic_st    = vic_way ? st_w1 : st_w0;
    vic_dirty = (vic_st == CS_M);
  end
endmodule

// File: rtl/ctc_coh_next.sv
`timescale 1ns/1ps
module ctc_coh_next
  import ctc_pkg::*;
(
  input  op_t      op,
  input  logic     hit,
  input  coh_t     cur,
  input  logic     shared,
  output coh_upd_t upd
);
  always_comb begin
    upd = '{en: 1'b0, st: cur, wb: 1'b0, upg: 1'b0};
    unique case (op)
      OP_WR: begin
        if (hit && cur != CS_M) begin
          upd.en  = 1'b1;
          upd.st  = CS_M;
          upd.upg = (cur == CS_S);
        end
      end
      OP_FILL: begin
        upd.en = 1'b1;
        upd.st = shared ? CS_S : CS_E;
      end
      OP_SRD: begin
        if (hit && (cur == CS_M || cur == CS_E)) begin
          upd.en = 1'b1;
          upd.st = CS_S;
          upd.wb = (cur == CS_M);
        end
      end
      OP_SINV: begin
        if (hit) begin
          upd.en = 1'b1;
          upd.st = CS_I;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
`timescale 1ns/1ps
module cache_tag_ctrl
  import ctc_pkg::*;
#(
  parameter int CAP_KB = 8,
  parameter int ADDR_W = 32,
  parameter int LINE_B = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_hit,
  output logic              cpu_way,
  output logic [1:0]        cpu_state,
  output logic              cpu_upgrade,
  output logic              cpu_wb,
  input  logic              fill_req,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_way,
  input  logic              fill_shared,
  input  logic              snp_req,
  input  logic              snp_inv,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_wb
);
  localparam int WAYS  = 2;
  localparam int SETS  = CAP_KB * 1024 / (WAYS * LINE_B);
  localparam int OFF_W = $clog2(LINE_B);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  // reset: asserted asynchronously, released on the second edge
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // request selection: snoop > fill > processor
  op_t              op;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  always_comb begin
    op  = OP_NONE;
    idx = cpu_addr[OFF_W +: IDX_W];
    tag = cpu_addr[ADDR_W-1 -: TAG_W];
    if (snp_req) begin
      op  = snp_inv ? OP_SINV : OP_SRD;
      idx = snp_addr[OFF_W +: IDX_W];
      tag = snp_addr[ADDR_W-1 -: TAG_W];
    end else if (fill_req) begin
      op  = OP_FILL;
      idx = fill_addr[OFF_W +: IDX_W];
      tag = fill_addr[ADDR_W-1 -: TAG_W];
    end else if (cpu_req) begin
      op  = cpu_we ? OP_WR : OP_RD;
    end
    if (!rst_int_n) op = OP_NONE;
  end

  logic unused_offsets;
  assign unused_offsets = ^{cpu_addr[OFF_W-1:0], fill_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

  // per-way storage and compare
  logic [TAG_W-1:0] way_tag [WAYS];
  coh_t             way_st  [WAYS];
  logic [WAYS-1:0]  match;
  logic [WAYS-1:0]  wr_st_en;
  logic [WAYS-1:0]  wr_tag_en;
  logic             tgt_way;
  coh_upd_t         upd;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w]     = (way_st[w] != CS_I) && (way_tag[w] == tag);
    assign wr_st_en[w]  = upd.en && (tgt_way == 1'(w));
    assign wr_tag_en[w] = (op == OP_FILL) && (fill_way == 1'(w));

    ctc_way_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .rd_idx   (idx),
      .rd_tag   (way_tag[w]),
      .rd_state (way_st[w]),
      .wr_st_en (wr_st_en[w]),
      .wr_tag_en(wr_tag_en[w]),
      .wr_idx   (idx),
      .wr_tag   (tag),
      .wr_state (upd.st)
    );
  end

  logic hit;
  logic hit_way;
  coh_t hit_st;

  always_comb begin
    hit     = |match;
    hit_way = match[1];
    if (match[1])      hit_st = way_st[1];
    else if (match[0]) hit_st = way_st[0];
    else               hit_st = CS_I;
  end

  logic lru_bit;
  logic vic_way;
  logic vic_dirty;

  ctc_victim u_victim (
    .st_w0    (way_st[0]),
    .st_w1    (way_st[1]),
    .lru      (lru_bit),
    .vic_way  (vic_way),
    .vic_dirty(vic_dirty)
  );

  ctc_coh_next u_coh (
    .op    (op),
    .hit   (hit),
    .cur   (hit_st),
    .shared(fill_shared),
    .upd   (upd)
  );

  logic cpu_sel;
  logic snp_sel;
  logic lru_en;

  assign cpu_sel = (op == OP_RD) || (op == OP_WR);
  assign snp_sel = (op == OP_SRD) || (op == OP_SINV);
  assign tgt_way = (op == OP_FILL) ? fill_way : hit_way;
  assign lru_en  = (op == OP_FILL) || (cpu_sel && hit);

  ctc_lru #(.SETS(SETS)) u_lru (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rd_idx (idx),
    .rd_lru (lru_bit),
    .upd_en (lru_en),
    .upd_idx(idx),
    .upd_val(~tgt_way)
  );

  assign cpu_hit     = cpu_sel && hit;
  assign cpu_way     = cpu_sel && (hit ? hit_way : vic_way);
  assign cpu_state   = cpu_sel ? hit_st : CS_I;
  assign cpu_upgrade = upd.upg;
  assign cpu_wb      = cpu_sel && !hit && vic_dirty;
  assign snp_hit     = snp_sel && hit;
  assign snp_wb      = upd.wb;

  // R2: a tag is never live in both ways of a set
  a_r2_single_way_match: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(match));

  // R7: the upgrade pulse only accompanies a write hit on a shared line
  a_r7_upgrade_only_from_shared: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_upgrade |-> (cpu_hit && cpu_we && cpu_state == CS_S));

  // R6: victim writeback belongs to a miss
  a_r6_wb_only_on_miss: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_wb |-> !cpu_hit);

  // R8: a snoop writeback needs a read snoop that found the line
  a_r8_snoop_wb_needs_hit: assert property (@(posedge clk) disable iff (!rst_int_n)
    snp_wb |-> (snp_hit && !snp_inv));

  // R10: a snoop silences the processor side
  a_r10_snoop_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_int_n)
    snp_req |-> !(cpu_hit || cpu_upgrade || cpu_wb));
endmodule

// File: tb/cache_tag_ctrl_tb.sv
`timescale 1ns/1ps
module cache_tag_ctrl_tb;
  localparam int SETS = 128;

  logic        clk;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr;
  logic        cpu_hit, cpu_way, cpu_upgrade, cpu_wb;
  logic [1:0]  cpu_state;
  logic        fill_req, fill_way, fill_shared;
  logic [31:0] fill_addr;
  logic        snp_req, snp_inv;
  logic [31:0] snp_addr;
  logic        snp_hit, snp_wb;

  cache_tag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_hit(cpu_hit), .cpu_way(cpu_way), .cpu_state(cpu_state),
    .cpu_upgrade(cpu_upgrade), .cpu_wb(cpu_wb),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_way(fill_way),
    .fill_shared(fill_shared),
    .snp_req(snp_req), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_wb(snp_wb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model: tags, states (0=I 1=S 2=E 3=M), replacement bits
  int mt [SETS][2];
  int ms [SETS][2];
  int ml [SETS];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [31:0] mk(int t, int i, int off);
    return {20'(t), 7'(i), 5'(off)};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit cr, bit cw, logic [31:0] ca, bit fr, logic [31:0] fa,
                      bit fw, bit fs, bit sr, bit si, logic [31:0] sa);
    int op, i, tg, hit, hw, hst, vw;
    bit h0, h1, cpuop, snpop, clash;
    logic [31:0] a;
    string rq;
    @(negedge clk);
    cpu_req = cr; cpu_we = cw; cpu_addr = ca;
    fill_req = fr; fill_addr = fa; fill_way = fw; fill_shared = fs;
    snp_req = sr; snp_inv = si; snp_addr = sa;
    #1;
    if (sr)      begin op = si ? 5 : 4; a = sa; end
    else if (fr) begin op = 3; a = fa; end
    else if (cr) begin op = cw ? 2 : 1; a = ca; end
    else         begin op = 0; a = ca; end
    if (!rst_n) op = 0;
    i  = int'(a[11:5]);
    tg = int'(a[31:12]);
    h0 = (ms[i][0] != 0) && (mt[i][0] == tg);
    h1 = (ms[i][1] != 0) && (mt[i][1] == tg);
    hit = int'(h0 | h1);
    hw  = h1 ? 1 : 0;
    hst = h1 ? ms[i][1] : (h0 ? ms[i][0] : 0);
    vw  = (ms[i][0] == 0) ? 0 : ((ms[i][1] == 0) ? 1 : ml[i]);
    cpuop = (op == 1) || (op == 2);
    snpop = (op >= 4);
    clash = cr && (sr || fr);
    rq = clash ? "R10" : (!rst_n ? "R1" : (hit != 0 ? "R2" : "R5"));
    chk(rq, "cpu_hit", int'(cpu_hit), int'(cpuop && hit != 0));
    chk((cpuop && hit == 0 && ms[i][0] != 0 && ms[i][1] != 0) ? "R4" : rq,
        "cpu_way", int'(cpu_way), cpuop ? (hit != 0 ? hw : vw) : 0);
    chk(rq, "cpu_state", int'(cpu_state), cpuop ? hst : 0);
    chk(clash ? "R10" : "R7", "cpu_upgrade", int'(cpu_upgrade),
        int'(op == 2 && hit != 0 && hst == 1));
    chk("R6", "cpu_wb", int'(cpu_wb), int'(cpuop && hit == 0 && ms[i][vw] == 3));
    chk(op == 5 ? "R9" : "R8", "snp_hit", int'(snp_hit), int'(snpop && hit != 0));
    chk(op == 5 ? "R9" : "R8", "snp_wb", int'(snp_wb), int'(op == 4 && hit != 0 && hst == 3));
    // model update at the coming edge
    case (op)
      1: if (hit != 0) ml[i] = 1 - hw;
      2: if (hit != 0) begin ms[i][hw] = 3; ml[i] = 1 - hw; end
      3: begin mt[i][fw] = tg; ms[i][fw] = fs ? 1 : 2; ml[i] = 1 - fw; end
      4: if (hit != 0 && hst >= 2) ms[i][hw] = 1;
      5: if (hit != 0) ms[i][hw] = 0;
      default: ;
    endcase
  endtask

  task automatic rd(logic [31:0] a);  step(1, 0, a, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(logic [31:0] a);  step(1, 1, a, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic fl(logic [31:0] a, bit w, bit s); step(0, 0, 0, 1, a, w, s, 0, 0, 0); endtask
  task automatic sn(logic [31:0] a, bit inv); step(0, 0, 0, 0, 0, 0, 0, 1, inv, a); endtask
  task automatic idle();              step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb, pc;
    for (int s = 0; s < SETS; s++) begin
      ml[s] = 0;
      for (int w = 0; w < 2; w++) begin mt[s][w] = 0; ms[s][w] = 0; end
    end
    cpu_req = 0; cpu_we = 0; cpu_addr = 0; fill_req = 0; fill_addr = 0;
    fill_way = 0; fill_shared = 0; snp_req = 0; snp_inv = 0; snp_addr = 0;
    rst_n = 0;
    pa = mk(10, 3, 0); pb = mk(11, 3, 0); pc = mk(12, 3, 0);
    // R1: requests during reset give all-zero responses
    step(1, 1, pa, 0, 0, 0, 0, 0, 0, 0);
    chk("R1", "cpu_hit in reset", int'(cpu_hit), 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, pa);
    chk("R1", "snp_hit in reset", int'(snp_hit), 0);
    @(negedge clk); rst_n = 1;
    idle(); idle(); idle();
    // R1/R5: empty cache misses toward way 0
    rd(pa);
    chk("R1", "empty victim way", int'(cpu_way), 0);
    fl(pa, 0, 0);                // R3: exclusive install
    rd(pa | 32'd5);              // R2: offset ignored
    chk("R3", "fill exclusive", int'(cpu_state), 2);
    wr(pa);                      // R7: E->M silent
    wr(pa | 32'd31);             // R7: M stays M
    chk("R7", "M stays M", int'(cpu_state), 3);
    rd(pb);                      // R5: way 1 invalid
    chk("R5", "second invalid way", int'(cpu_way), 1);
    fl(pb, 1, 1);                // R3: shared install
    wr(pb);                      // R7: S->M with upgrade
    chk("R7", "upgrade pulse", int'(cpu_upgrade), 1);
    rd(pc);                      // R4/R6: victim way 0 (M) by replacement bit
    chk("R6", "dirty victim wb", int'(cpu_wb), 1);
    rd(pa);                      // R4: steer replacement toward way 1
    rd(pc);
    chk("R4", "victim follows hit", int'(cpu_way), 1);
    sn(pa, 0);                   // R8: M -> S with writeback
    chk("R8", "snoop wb on M", int'(snp_wb), 1);
    sn(pa, 0);                   // R8: S stays, no wb
    sn(pa, 1);                   // R9: invalidate
    rd(pa);
    chk("R9", "line gone", int'(cpu_hit), 0);
    // R10: write to B collides with a snoop read of B
    step(1, 1, pb, 0, 0, 0, 0, 1, 0, pb);
    chk("R10", "snoop wins", int'(snp_wb), 1);
    rd(pb);
    chk("R10", "dropped write", int'(cpu_state), 1);
    // R10: fill beats processor
    step(1, 1, pb, 1, pc, 0, 0, 0, 0, 0);
    rd(pc);
    chk("R3", "fill over cpu", int'(cpu_way), 0);
    sn(pc, 0);                   // R8: E -> S silently
    rd(pc);
    chk("R8", "E to S", int'(cpu_state), 1);
    // randomized phase on a small address pool
    for (int n = 0; n < 4000; n++) begin
      int r, i0, h;
      bit cr, cw, fr, fw, fs, sr, si;
      logic [31:0] ca, fa, sa;
      r  = $urandom_range(0, 9);
      ca = mk($urandom_range(1, 4), $urandom_range(3, 4), $urandom_range(0, 31));
      fa = mk($urandom_range(1, 4), $urandom_range(3, 4), $urandom_range(0, 31));
      sa = mk($urandom_range(1, 4), $urandom_range(3, 4), $urandom_range(0, 31));
      cr = (r < 6) || (r == 9);
      cw = $urandom_range(0, 1) != 0;
      fr = (r == 6) || (r == 9);
      fw = $urandom_range(0, 1) != 0;
      fs = $urandom_range(0, 1) != 0;
      sr = (r == 7) || (r == 8);
      si = (r == 8) && ($urandom_range(0, 2) == 0);
      if (sr && $urandom_range(0, 3) == 0) cr = 1;
      i0 = int'(fa[11:5]);
      h  = 0;
      for (int w = 0; w < 2; w++)
        if (ms[i0][w] != 0 && mt[i0][w] == int'(fa[31:12])) h = 1;
      if (h != 0) fr = 0;
      step(cr, cw, ca, fr, fa, fw, fs, sr, si, sa);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule